// File: doc/BRIEF.md
# Square-Wave Phase-Accumulator Oscillator with Atomic Retune

This block makes a 50% duty square wave whose frequency is set by a tuning word. Fine frequency steps come from accumulation, not from a clock divider. A 24-bit phase accumulator adds the active tuning word on every enabled clock, and the accumulator's top bit drives the output. The output frequency is f_clk × word / 2^24. At a 125 MHz clock one tuning LSB is about 7.45 Hz, and a word near 10066 gives about 75 kHz.

Every output edge falls on a clock edge. When 2^24 / word is not an integer, consecutive periods alternate between the floor and the ceiling of that ratio. Only the average over many periods is exact.

A host writes the word one byte at a time into shadow registers, with byte address 0 as the least significant byte. A separate commit strobe then copies all shadow bytes into the active word in one clock, so the accumulator never sees a partly written value. A commit leaves the accumulator alone, so the phase stays continuous across a retune.

The output comes from a two-state machine:
- OUT_LOW and OUT_HIGH are the two states.
- The "rise" transition moves OUT_LOW to OUT_HIGH when the updated accumulator's top bit is 1.
- The "fall" transition moves OUT_HIGH to OUT_LOW when that bit is 0.
- Otherwise the machine stays in its state.
- Reset forces OUT_LOW.

Top module: `sqwave_nco`

## Requirements
- R1: Synchronous active-high reset clears the accumulator, the shadow bytes and the active word, and drives sq_out low at the next edge. After reset with no commit, sq_out stays low even with enable high.
- R2: On each clock edge with enable high and reset low, the accumulator becomes (accumulator + active word) mod 2^24, using the word in force before that edge. sq_out equals the top bit of the updated accumulator, registered at the same edge.
- R3: A write with wr_addr 0, 1 or 2 stores wr_data into bits [7:0], [15:8] or [23:16] of the shadow word. A write with wr_addr 3 changes nothing.
- R4: Shadow writes without a commit do not change the active word or sq_out.
- R5: A commit copies the shadow word into the active word at the next edge. A byte written in the same cycle as a commit lands only in the shadow word; the commit copies the value from before that write.
- R6: A commit does not clear or move the accumulator. The accumulator only continues from its current value with the new word.
- R7: While enable is low, the accumulator and sq_out hold their values.
- R8: With an active word of zero, sq_out stays at a constant level.
- R9: For a word W, each full output period lasts floor(2^24/W) or ceil(2^24/W) clocks. Each high phase lasts floor(2^23/W) or ceil(2^23/W) clocks.
- R10: The accumulator wraps modulo 2^24. With word 0x800000, sq_out toggles on every enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accumulator advance enable |
| wr_en | input | 1 | Byte write strobe into the shadow word |
| wr_addr | input | 2 | Byte lane select, 0 = least significant |
| wr_data | input | 8 | Byte to store |
| commit | input | 1 | Copies the shadow word into the active word |
| sq_out | output | 1 | Registered square-wave output |

## Verification
The hardest case to reach from the ports is a byte write and a commit in the same clock. It shows whether the commit picks up the shadow value from before or after that write, and it needs both strobes driven together in one cycle. A second hard case is phase continuity across a retune: it only shows up if the accumulator already holds a non-zero phase when the new word arrives. The stimulus handles both by retuning mid-run from several non-zero words. A cycle-exact model of the accumulator in the bench predicts every output bit. Period and high-time counts on a word near 75 kHz check the floor/ceiling alternation.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int DEF_ACC_W  = 24;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_e;
endpackage

// File: rtl/nco_tune_regs.sv
module nco_tune_regs #(
    parameter int ACC_W  = nco_pkg::DEF_ACC_W,
    parameter int BYTE_W = nco_pkg::DEF_BYTE_W,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              commit,
    output logic [ACC_W-1:0]  shadow_word,
    output logic [ACC_W-1:0]  tune_word
);
    localparam int NBYTES = ACC_W / BYTE_W;

    logic [BYTE_W-1:0] shadow_q [NBYTES];
    logic [ACC_W-1:0]  tune_q;

    // One register per byte lane; addresses at or above NBYTES select no lane.
    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[gi] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
                shadow_q[gi] <= wr_data;
            end
        end
        assign shadow_word[gi*BYTE_W +: BYTE_W] = shadow_q[gi];
    end

    // The whole word moves on one edge; the old shadow value is taken even if a lane is written now.
    always_ff @(posedge clk) begin
        if (rst) begin
            tune_q <= '0;
        end else if (commit) begin
            tune_q <= shadow_word;
        end
    end

    assign tune_word = tune_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = nco_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [ACC_W-1:0] tune_word,
    output logic [ACC_W-1:0] acc,
    output logic             msb_next
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    // Truncation to ACC_W bits gives the modulo wrap.
    always_comb begin
        acc_d = adv ? (acc_q + tune_word) : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc      = acc_q;
    assign msb_next = acc_d[ACC_W-1];
endmodule

// File: rtl/nco_edge_fsm.sv
module nco_edge_fsm
    import nco_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic msb_next,
    output logic sq_out
);
    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_LOW:  if (msb_next)  state_d = OUT_HIGH;
            OUT_HIGH: if (!msb_next) state_d = OUT_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode reads only the state register, so the pin is glitch-free.
    always_comb begin
        sq_out = (state_q == OUT_HIGH);
    end
endmodule

// File: rtl/sqwave_nco.sv
module sqwave_nco #(
    parameter int  ACC_W  = nco_pkg::DEF_ACC_W,
    parameter int  BYTE_W = nco_pkg::DEF_BYTE_W,
    localparam int NBYTES = ACC_W / BYTE_W,
    localparam int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES + 1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              commit,
    output logic              sq_out
);
    logic [ACC_W-1:0] shadow_w;
    logic [ACC_W-1:0] tune_w;
    logic [ACC_W-1:0] acc_w;
    logic             msb_next_w;

    nco_tune_regs #(.ACC_W(ACC_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .shadow_word (shadow_w),
        .tune_word   (tune_w)
    );

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .adv       (en),
        .tune_word (tune_w),
        .acc       (acc_w),
        .msb_next  (msb_next_w)
    );

    nco_edge_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .msb_next (msb_next_w),
        .sq_out   (sq_out)
    );
endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
    parameter int ACC_W = nco_pkg::DEF_ACC_W
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             commit,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] tw,
    input logic [ACC_W-1:0] shadow,
    input logic             sq_out
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!sq_out && acc == '0 && tw == '0));

    p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> acc == ACC_W'($past(acc) + $past(tw)));

    p_out_follows_msb_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> sq_out == acc[ACC_W-1]);

    p_word_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(tw));

    p_commit_loads_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> tw == $past(shadow));

    p_hold_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc) && $stable(sq_out)));

    p_zero_word_flat_r8: assert property (@(posedge clk) disable iff (rst)
        (tw == '0) |=> $stable(sq_out));
endmodule

bind sqwave_nco nco_checker #(.ACC_W(ACC_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .commit (commit),
    .acc    (acc_w),
    .tw     (tune_w),
    .shadow (shadow_w),
    .sq_out (sq_out)
);

// File: tb/tb_sqwave_nco.sv
module tb_sqwave_nco;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       commit = 1'b0;
    logic       sq_out;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";

    bit    exp_q [$];
    string tag_q [$];

    logic [7:0]  m_sh [3];
    logic [23:0] m_tw = '0;
    logic [23:0] m_acc = '0;

    always #4 clk = ~clk;

    sqwave_nco dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .sq_out  (sq_out)
    );

    task automatic check(input bit ok, input string t, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    // Reference model, from R1-style rules written per requirement (R2, R3, R5, R6, R10).
    always @(posedge clk) begin : model
        logic [23:0] nacc;
        logic [23:0] shw;
        if (rst) begin
            for (int i = 0; i < 3; i++) m_sh[i] = 8'd0;
            m_tw  = '0;
            m_acc = '0;
        end else begin
            shw  = {m_sh[2], m_sh[1], m_sh[0]};
            nacc = en ? (m_acc + m_tw) : m_acc;
            if (commit) m_tw = shw;
            if (wr_en && wr_addr < 2'd3) m_sh[wr_addr] = wr_data;
            m_acc = nacc;
        end
        exp_q.push_back(m_acc[23]);
        tag_q.push_back(tag);
    end

    always @(negedge clk) begin : monitor
        bit    e;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(sq_out === e, {t, " scoreboard"}, int'(sq_out), int'(e));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbyte(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_word(input logic [23:0] w);
        wbyte(2'd0, w[7:0]);
        wbyte(2'd1, w[15:8]);
        wbyte(2'd2, w[23:16]);
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic count_toggles(input int n, output int cnt);
        logic prev;
        cnt = 0;
        prev = sq_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sq_out !== prev) cnt++;
            prev = sq_out;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = sq_out;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!prev && sq_out) break;
            prev = sq_out;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : driver
        int cnt;
        logic snap;
        int lo_p, hi_p, lo_h, hi_h, per, high;
        logic [23:0] w;

        // R1: reset state
        tag = "R1";
        repeat (5) @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        check(sq_out === 1'b0, "R1 low after reset", int'(sq_out), 0);
        idle(20);
        check(sq_out === 1'b0, "R1 zero word keeps low", int'(sq_out), 0);

        // R4: shadow writes alone change nothing
        tag = "R4";
        set_word(24'h400000);
        count_toggles(30, cnt);
        check(cnt == 0, "R4 no toggles before commit", cnt, 0);

        // R5: commit applies the word (toggle every 2 clocks)
        tag = "R5";
        do_commit();
        idle(2);
        count_toggles(16, cnt);
        check(cnt == 8, "R5 word 0x400000 toggles", cnt, 8);

        // R3: address 3 ignored, byte order LSB first
        tag = "R3";
        wbyte(2'd3, 8'hFF);
        do_commit();
        idle(2);
        count_toggles(16, cnt);
        check(cnt == 8, "R3 addr 3 ignored", cnt, 8);
        wbyte(2'd2, 8'h20);
        wbyte(2'd1, 8'h00);
        wbyte(2'd0, 8'h00);
        do_commit();
        idle(2);
        count_toggles(16, cnt);
        check(cnt == 4, "R3 byte 2 is the top lane", cnt, 4);

        // R5: write and commit in the same cycle take the old shadow value
        tag = "R5";
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h40; commit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; commit = 1'b0;
        idle(2);
        count_toggles(16, cnt);
        check(cnt == 4, "R5 same-cycle commit uses old shadow", cnt, 4);
        do_commit();
        idle(2);
        count_toggles(16, cnt);
        check(cnt == 8, "R5 later commit picks up new byte", cnt, 8);

        // R6: retune mid-run from a non-zero phase, scoreboard checks continuity
        tag = "R6";
        set_word(24'h123457);
        do_commit();
        idle(37);
        w = 24'd10066;
        set_word(w);
        do_commit();
        idle(5);

        // R9: period and high time near 75 kHz at 125 MHz
        tag = "R9";
        lo_p = (1 << 24) / int'(w);
        hi_p = ((1 << 24) % int'(w) != 0) ? lo_p + 1 : lo_p;
        lo_h = (1 << 23) / int'(w);
        hi_h = ((1 << 23) % int'(w) != 0) ? lo_h + 1 : lo_h;
        wait_rise();
        for (int p = 0; p < 4; p++) begin
            per = 0;
            high = 0;
            snap = sq_out;
            forever begin
                @(negedge clk);
                per++;
                if (snap) high++;
                if (!snap && sq_out) break;
                snap = sq_out;
            end
            check(per == lo_p || per == hi_p, "R9 period", per, lo_p);
            check(high == lo_h || high == hi_h, "R9 high time", high, lo_h);
        end

        // R10: half-scale word toggles every clock through wrap
        tag = "R10";
        set_word(24'h800000);
        do_commit();
        idle(2);
        count_toggles(8, cnt);
        check(cnt == 8, "R10 toggles every clock", cnt, 8);

        // R7: enable low holds output
        tag = "R7";
        en = 1'b0;
        snap = sq_out;
        count_toggles(20, cnt);
        check(cnt == 0 && sq_out === snap, "R7 hold while disabled", cnt, 0);
        en = 1'b1;
        idle(3);

        // R8: zero word keeps a constant level
        tag = "R8";
        set_word(24'h000000);
        do_commit();
        idle(2);
        count_toggles(40, cnt);
        check(cnt == 0, "R8 zero word flat", cnt, 0);

        // R1: reset mid-run
        tag = "R1";
        set_word(24'h400000);
        do_commit();
        idle(10);
        rst = 1'b1;
        @(negedge clk);
        check(sq_out === 1'b0, "R1 low after mid-run reset", int'(sq_out), 0);
        rst = 1'b0;
        count_toggles(20, cnt);
        check(cnt == 0 && sq_out === 1'b0, "R1 word cleared by reset", cnt, 0);

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule